// File: doc/BRIEF.md
# Lookup-Table Fan Duty Controller

This block turns temperature readings from four thermal zones into a 4-bit duty step code for each of two fan outputs. It also drives a simple PWM waveform from each code. The zones are grouped into two pairs, and each pair shares one threshold staircase. The first threshold of a staircase is a base temperature. Each later threshold adds one 4-bit offset from a table onto the threshold before it. A zone's level is the number of thresholds its temperature lies strictly above. A hysteresis margin keeps the level from falling back until the temperature has dropped that far below the threshold it crossed. Before any comparison, zone 0 receives a signed correction, and the corrected value is clamped to the 8-bit range.

Each output takes the largest demand among the zones and hot-input ramps that its enable bits bind to it. A ramp follows a three-state machine. RAMP_IDLE holds the ramp at zero. On a high hot input it takes the transition *arm* into RAMP_CLIMB, which adds one step per delay interval up to full scale. On a low hot input it takes *cool* into RAMP_DECAY, which removes one step per interval. A hot input that returns takes *rearm* back to RAMP_CLIMB. When the ramp reaches zero it takes *settle* back to RAMP_IDLE. A low run enable forces every machine back to RAMP_IDLE (*halt*).

A per-output manual duty can replace the automatic result, and a global full-speed input overrides everything. A per-output polarity bit inverts the waveform.

Top module: `fan_duty_ctrl`

## Requirements
- R1: Thresholds are T0 = base and Tk = T(k-1) + offset(k-1) for k = 1..7, where offset j sits at bits [4j+3:4j] of the pair's table. The level is the count of thresholds below the temperature, and a zone's demand is min(15, floor + level).
- R2: The level is registered and updates on each clock. It rises to the upward count when that count is larger. It falls only to the count of thresholds below temperature + hysteresis, and only when that count is smaller than the current level.
- R3: Zones 0 and 1 use pair 0 (base, table, hysteresis, floor), and zones 2 and 3 use pair 1. Pair p's fields sit at slice p of each pair bus.
- R4: Zone 0's temperature has the 6-bit two's complement correction added to it, and the result is clamped to 0..255 before any comparison.
- R5: Bit o*4+z of zone_bind binds zone z to output o. The automatic duty of an output is the maximum demand of its bound zones and bound ramps, and 0 when nothing is bound.
- R6: Bit o*2+h of hot_bind binds hot input h to output o. The cycle after hot_in[h] rises, the ramp enters RAMP_CLIMB. From then on it gains one step each ramp_div+1 cycles and saturates at 15.
- R7: With the hot input low, the ramp loses one step each ramp_div+1 cycles down to 0 and then returns to RAMP_IDLE. When two ramps are bound to one output, the larger one counts.
- R8: When man_en[o] is set, duty_code[o] equals man_duty[o].
- R9: full_speed forces every duty_code to 15. This takes priority over the manual duty.
- R10: A 15-slot counter (0..14) runs continuously, and pwm_out[o] = (counter < duty) XOR pwm_inv[o]. With the polarity bit clear, a duty of 15 keeps the output continuously high.
- R11: While run_en is low, every zone's demand is its pair floor, ramps contribute 0, and levels and ramps clear on the next clock.
- R12: After reset, all levels are 0, the ramps are in RAMP_IDLE at 0 and the PWM counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Enables the automatic algorithm |
| zone_temp | input | 32 | Four 8-bit zone temperatures, zone z at [8z+7:8z] |
| zone0_adj | input | 6 | Signed correction for zone 0 |
| pair_offs | input | 56 | Two 28-bit tables of seven 4-bit offsets |
| pair_base | input | 16 | Base temperature per pair |
| pair_hyst | input | 8 | Hysteresis per pair |
| pair_floor | input | 8 | Minimum duty per pair |
| zone_bind | input | 8 | Zone-to-output enables |
| hot_bind | input | 4 | Hot-input-to-output enables |
| hot_in | input | 2 | Hot inputs, active high |
| ramp_div | input | 8 | Ramp step interval minus one, in cycles |
| man_en | input | 2 | Manual duty select per output |
| man_duty | input | 8 | Manual duty code per output |
| full_speed | input | 1 | Forces all outputs to full duty |
| pwm_inv | input | 2 | Output polarity per output |
| duty_code | output | 8 | Final duty code per output |
| pwm_out | output | 2 | PWM waveform per output |

## Verification
The assertions assume that ramp_div changes only while no ramp is active, because the ramp's single-step property relies on the tick interval staying fixed. They also assume that the bound floor comparison refers to pair 0's floor. The stimulus loads ramp_div only while the hot inputs are low and the ramps have drained. Temperatures are kept as 8-bit values that drift by a few degrees per cycle, so the hysteresis band is crossed in both directions. Corrections are drawn from the full signed range, which includes the clamp extremes.

// File: rtl/fan_duty_pkg.sv
package fan_duty_pkg;

    typedef enum logic [1:0] {
        RAMP_IDLE  = 2'd0,
        RAMP_CLIMB = 2'd1,
        RAMP_DECAY = 2'd2
    } ramp_state_e;

endpackage

// File: rtl/fan_zone_level.sv
module fan_zone_level #(
    parameter int TW    = 8,
    parameter int OW    = 4,
    parameter int HW    = 4,
    parameter int NSTEP = 8,
    localparam int LW   = $clog2(NSTEP + 1),
    localparam int TBW  = (NSTEP - 1) * OW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run_en,
    input  logic [TW-1:0]  temp,
    input  logic [TW-1:0]  base,
    input  logic [TBW-1:0] offs,
    input  logic [HW-1:0]  hyst,
    output logic [LW-1:0]  level
);
    localparam int SW = TW + $clog2(NSTEP) + 2;

    logic [SW-1:0] thr, t_ext, t_hi;
    logic [LW-1:0] n_up, n_dn, level_q;

    // walk the staircase, counting thresholds below the reading and below reading+hysteresis
    always_comb begin
        t_ext = SW'(temp);
        t_hi  = t_ext + SW'(hyst);
        thr   = SW'(base);
        n_up  = (t_ext > thr) ? LW'(1) : '0;
        n_dn  = (t_hi > thr) ? LW'(1) : '0;
        for (int k = 0; k < NSTEP - 1; k++) begin
            thr = thr + SW'(offs[k*OW +: OW]);
            if (t_ext > thr) n_up = n_up + LW'(1);
            if (t_hi > thr)  n_dn = n_dn + LW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               level_q <= '0;
        else if (!run_en)         level_q <= '0;
        else if (n_up > level_q)  level_q <= n_up;
        else if (n_dn < level_q)  level_q <= n_dn;
    end

    assign level = level_q;

    AST_LEVEL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        level_q <= LW'(NSTEP)); // R1

    AST_HALT_CLEARS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> level_q == '0); // R11

endmodule

// File: rtl/fan_hot_ramp.sv
module fan_hot_ramp
    import fan_duty_pkg::*;
#(
    parameter int DW   = 4,
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_en,
    input  logic            hot,
    input  logic [DIVW-1:0] div,
    output logic [DW-1:0]   level
);
    localparam logic [DW-1:0] TOP = '1;

    ramp_state_e     st_q, st_d;
    logic [DIVW-1:0] tmr_q, tmr_d;
    logic [DW-1:0]   lv_q, lv_d;
    logic            tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= RAMP_IDLE;
            tmr_q <= '0;
            lv_q  <= '0;
        end else begin
            st_q  <= st_d;
            tmr_q <= tmr_d;
            lv_q  <= lv_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        tmr_d = tmr_q;
        lv_d  = lv_q;
        tick  = (tmr_q == div);
        if (!run_en) begin
            st_d  = RAMP_IDLE;
            tmr_d = '0;
            lv_d  = '0;
        end else begin
            unique case (st_q)
                RAMP_IDLE: begin
                    tmr_d = '0;
                    if (hot) st_d = RAMP_CLIMB;
                end
                RAMP_CLIMB: begin
                    tmr_d = tick ? '0 : tmr_q + 1'b1;
                    if (tick && lv_q != TOP) lv_d = lv_q + 1'b1;
                    if (!hot) st_d = RAMP_DECAY;
                end
                RAMP_DECAY: begin
                    tmr_d = tick ? '0 : tmr_q + 1'b1;
                    if (hot) begin
                        st_d = RAMP_CLIMB;
                        if (tick && lv_q != '0) lv_d = lv_q - 1'b1;
                    end else if (lv_q == '0 || (tick && lv_q == DW'(1))) begin
                        st_d  = RAMP_IDLE;
                        lv_d  = '0;
                        tmr_d = '0;
                    end else if (tick) begin
                        lv_d = lv_q - 1'b1;
                    end
                end
                default: st_d = RAMP_IDLE;
            endcase
        end
    end

    assign level = lv_q;

    AST_RAMP_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && $past(run_en)) |->
            (lv_q == $past(lv_q) || lv_q == $past(lv_q) + 1'b1 || lv_q + 1'b1 == $past(lv_q))); // R6

    AST_IDLE_RAMP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == RAMP_IDLE |-> lv_q == '0); // R7

endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen #(
    parameter int NOUT = 2,
    parameter int DW   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NOUT*DW-1:0] duty,
    input  logic [NOUT-1:0]    inv,
    output logic [NOUT-1:0]    pwm
);
    localparam logic [DW-1:0] LAST = DW'((1 << DW) - 2);

    logic [DW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (cnt_q == LAST)  cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end

    for (genvar o = 0; o < NOUT; o++) begin : g_out
        assign pwm[o] = (cnt_q < duty[o*DW +: DW]) ^ inv[o];
    end

    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R10

endmodule

// File: rtl/fan_duty_ctrl.sv
module fan_duty_ctrl
    import fan_duty_pkg::*;
#(
    parameter int NZONE = 4,
    parameter int NOUT  = 2,
    parameter int NHOT  = 2,
    parameter int TW    = 8,
    parameter int DW    = 4,
    parameter int OW    = 4,
    parameter int HW    = 4,
    parameter int AW    = 6,
    parameter int NSTEP = 8,
    parameter int DIVW  = 8,
    localparam int NPAIR = NZONE / 2,
    localparam int TBW   = (NSTEP - 1) * OW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_en,
    input  logic [NZONE*TW-1:0] zone_temp,
    input  logic [AW-1:0]       zone0_adj,
    input  logic [NPAIR*TBW-1:0] pair_offs,
    input  logic [NPAIR*TW-1:0] pair_base,
    input  logic [NPAIR*HW-1:0] pair_hyst,
    input  logic [NPAIR*DW-1:0] pair_floor,
    input  logic [NOUT*NZONE-1:0] zone_bind,
    input  logic [NOUT*NHOT-1:0] hot_bind,
    input  logic [NHOT-1:0]     hot_in,
    input  logic [DIVW-1:0]     ramp_div,
    input  logic [NOUT-1:0]     man_en,
    input  logic [NOUT*DW-1:0]  man_duty,
    input  logic                full_speed,
    input  logic [NOUT-1:0]     pwm_inv,
    output logic [NOUT*DW-1:0]  duty_code,
    output logic [NOUT-1:0]     pwm_out
);
    localparam int LW   = $clog2(NSTEP + 1);
    localparam int SUMW = DW + LW;
    localparam int XW   = TW + 2;
    localparam logic [DW-1:0] DMAX = '1;

    logic signed [XW-1:0] adj_sum;
    logic [TW-1:0]        z0_temp;
    logic [DW-1:0]        zone_dem [NZONE];
    logic [DW-1:0]        ramp_dem [NHOT];

    // zone 0 correction with saturation to the reading range
    always_comb begin
        adj_sum = signed'({2'b00, zone_temp[TW-1:0]}) + XW'(signed'(zone0_adj));
        if (adj_sum < 0)                               z0_temp = '0;
        else if (adj_sum > signed'(XW'((1 << TW) - 1))) z0_temp = '1;
        else                                           z0_temp = adj_sum[TW-1:0];
    end

    for (genvar z = 0; z < NZONE; z++) begin : g_zone
        localparam int P = z / 2;
        logic [TW-1:0]   t_in;
        logic [LW-1:0]   lvl;
        logic [SUMW-1:0] s;
        if (z == 0) begin : g_adj
            assign t_in = z0_temp;
        end else begin : g_raw
            assign t_in = zone_temp[z*TW +: TW];
        end
        fan_zone_level #(.TW(TW), .OW(OW), .HW(HW), .NSTEP(NSTEP)) u_level (
            .clk    (clk),
            .rst_n  (rst_n),
            .run_en (run_en),
            .temp   (t_in),
            .base   (pair_base[P*TW +: TW]),
            .offs   (pair_offs[P*TBW +: TBW]),
            .hyst   (pair_hyst[P*HW +: HW]),
            .level  (lvl)
        );
        assign s = SUMW'(pair_floor[P*DW +: DW]) + SUMW'(lvl);
        assign zone_dem[z] = !run_en ? pair_floor[P*DW +: DW]
                           : (s > SUMW'(DMAX)) ? DMAX : s[DW-1:0];
    end

    for (genvar h = 0; h < NHOT; h++) begin : g_hot
        logic [DW-1:0] r;
        fan_hot_ramp #(.DW(DW), .DIVW(DIVW)) u_ramp (
            .clk    (clk),
            .rst_n  (rst_n),
            .run_en (run_en),
            .hot    (hot_in[h]),
            .div    (ramp_div),
            .level  (r)
        );
        assign ramp_dem[h] = run_en ? r : '0;
    end

    // per output: maximum of bound sources, then manual, then global force
    always_comb begin
        for (int o = 0; o < NOUT; o++) begin
            logic [DW-1:0] best;
            best = '0;
            for (int z = 0; z < NZONE; z++)
                if (zone_bind[o*NZONE + z] && zone_dem[z] > best) best = zone_dem[z];
            for (int h = 0; h < NHOT; h++)
                if (hot_bind[o*NHOT + h] && ramp_dem[h] > best) best = ramp_dem[h];
            if (full_speed)     duty_code[o*DW +: DW] = DMAX;
            else if (man_en[o]) duty_code[o*DW +: DW] = man_duty[o*DW +: DW];
            else                duty_code[o*DW +: DW] = best;
        end
    end

    fan_pwm_gen #(.NOUT(NOUT), .DW(DW)) u_pwm (
        .clk   (clk),
        .rst_n (rst_n),
        .duty  (duty_code),
        .inv   (pwm_inv),
        .pwm   (pwm_out)
    );

    AST_FULL_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        full_speed |-> pwm_out == ~pwm_inv); // R9

    for (genvar o = 0; o < NOUT; o++) begin : g_chk
        AST_MAN_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            (!full_speed && man_en[o] && man_duty[o*DW +: DW] == '0) |-> pwm_out[o] == pwm_inv[o]); // R8

        AST_HALT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
            (!run_en && !full_speed && !man_en[o] && zone_bind[o*NZONE])
                |-> duty_code[o*DW +: DW] >= pair_floor[DW-1:0]); // R11
    end

endmodule

// File: tb/test_fan_duty_ctrl.sv
module test_fan_duty_ctrl;
    localparam int NZONE = 4, NOUT = 2, NHOT = 2, TW = 8, DW = 4, NSTEP = 8;
    localparam int NPAIR = 2, TBW = (NSTEP - 1) * 4;

    logic clk = 1'b0;
    logic rst_n, run_en, full_speed;
    logic [NZONE*TW-1:0] zone_temp;
    logic [5:0] zone0_adj;
    logic [NPAIR*TBW-1:0] pair_offs;
    logic [NPAIR*TW-1:0] pair_base;
    logic [NPAIR*4-1:0] pair_hyst, pair_floor;
    logic [NOUT*NZONE-1:0] zone_bind;
    logic [NOUT*NHOT-1:0] hot_bind;
    logic [NHOT-1:0] hot_in;
    logic [7:0] ramp_div;
    logic [NOUT-1:0] man_en, pwm_inv, pwm_out;
    logic [NOUT*DW-1:0] man_duty, duty_code;

    fan_duty_ctrl i_fan_duty_ctrl (.*);

    always #2 clk = ~clk;

    int n_vec = 0, n_bad = 0;
    int m_lvl [NZONE];
    int m_r [NHOT], m_st [NHOT], m_tmr [NHOT];
    int m_cnt;

    function automatic int eff_temp(int z);
        int t, a;
        t = zone_temp[z*TW +: TW];
        if (z == 0) begin
            a = zone0_adj;
            if (a >= 32) a -= 64;
            t = t + a;
            if (t < 0) t = 0;
            if (t > 255) t = 255;
        end
        return t;
    endfunction

    function automatic int count_below(int t, int p);
        int thr, n;
        thr = pair_base[p*TW +: TW];
        n = (t > thr) ? 1 : 0;
        for (int k = 0; k < NSTEP - 1; k++) begin
            thr += pair_offs[p*TBW + k*4 +: 4];
            if (t > thr) n++;
        end
        return n;
    endfunction

    function automatic int zone_demand(int z);
        int f, d;
        f = pair_floor[(z/2)*4 +: 4];
        if (!run_en) return f;
        d = f + m_lvl[z];
        return (d > 15) ? 15 : d;
    endfunction

    function automatic int exp_duty(int o);
        int best, d;
        best = 0;
        for (int z = 0; z < NZONE; z++) begin
            d = zone_demand(z);
            if (zone_bind[o*NZONE + z] && d > best) best = d;
        end
        for (int h = 0; h < NHOT; h++) begin
            d = run_en ? m_r[h] : 0;
            if (hot_bind[o*NHOT + h] && d > best) best = d;
        end
        if (full_speed) return 15;
        if (man_en[o]) return man_duty[o*DW +: DW];
        return best;
    endfunction

    // reference model: ramp states 0 idle, 1 climb, 2 decay
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NZONE; i++) m_lvl[i] = 0;
            for (int h = 0; h < NHOT; h++) begin m_r[h] = 0; m_st[h] = 0; m_tmr[h] = 0; end
            m_cnt = 0;
        end else begin
            for (int z = 0; z < NZONE; z++) begin
                int up, dn;
                up = count_below(eff_temp(z), z/2);
                dn = count_below(eff_temp(z) + pair_hyst[(z/2)*4 +: 4], z/2);
                if (!run_en) m_lvl[z] = 0;
                else if (up > m_lvl[z]) m_lvl[z] = up;
                else if (dn < m_lvl[z]) m_lvl[z] = dn;
            end
            for (int h = 0; h < NHOT; h++) begin
                bit tk;
                tk = (m_tmr[h] == ramp_div);
                if (!run_en) begin m_st[h] = 0; m_r[h] = 0; m_tmr[h] = 0; end
                else if (m_st[h] == 0) begin
                    m_tmr[h] = 0;
                    if (hot_in[h]) m_st[h] = 1;
                end else if (m_st[h] == 1) begin
                    m_tmr[h] = tk ? 0 : m_tmr[h] + 1;
                    if (tk && m_r[h] < 15) m_r[h]++;
                    if (!hot_in[h]) m_st[h] = 2;
                end else begin
                    m_tmr[h] = tk ? 0 : m_tmr[h] + 1;
                    if (hot_in[h]) begin
                        m_st[h] = 1;
                        if (tk && m_r[h] > 0) m_r[h]--;
                    end else if (m_r[h] == 0 || (tk && m_r[h] == 1)) begin
                        m_st[h] = 0; m_r[h] = 0; m_tmr[h] = 0;
                    end else if (tk) m_r[h]--;
                end
            end
            m_cnt = (m_cnt == 14) ? 0 : m_cnt + 1;
        end
    end

    task automatic chk(string tag);
        for (int o = 0; o < NOUT; o++) begin
            int ed, ep;
            ed = exp_duty(o);
            ep = ((m_cnt < ed) ? 1 : 0) ^ int'(pwm_inv[o]);
            n_vec++;
            if (int'(duty_code[o*DW +: DW]) != ed) begin
                n_bad++;
                $display("FAIL %s duty_code[%0d] got %0d expected %0d", tag, o, duty_code[o*DW +: DW], ed);
            end
            n_vec++;
            if (int'(pwm_out[o]) != ep) begin
                n_bad++;
                $display("FAIL %s pwm_out[%0d] got %0d expected %0d", tag, o, pwm_out[o], ep);
            end
        end
    endtask

    task automatic step(int n, string tag);
        repeat (n) begin
            @(negedge clk);
            chk(tag);
        end
    endtask

    task automatic fill_offs(int p, int v);
        for (int k = 0; k < NSTEP - 1; k++) pair_offs[p*TBW + k*4 +: 4] = 4'(v);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R12 watchdog got running expected finished");
        summary();
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 0; run_en = 0; full_speed = 0; zone_temp = '0; zone0_adj = '0;
        pair_offs = '0; pair_base = '0; pair_hyst = '0; pair_floor = '0;
        zone_bind = '0; hot_bind = '0; hot_in = '0; ramp_div = '0;
        man_en = '0; man_duty = '0; pwm_inv = '0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        step(3, "R12");

        // staircase on pair 0 (zone 1) and pair 1 (zone 2)
        run_en = 1;
        pair_base = {8'd100, 8'd40};
        fill_offs(0, 5); fill_offs(1, 10);
        pair_floor = {4'd3, 4'd2};
        zone_bind = 8'b0100_0010;
        for (int t = 30; t < 110; t++) begin
            zone_temp[1*TW +: TW] = 8'(t);
            zone_temp[2*TW +: TW] = 8'(t + 60);
            step(2, "R1");
        end
        step(4, "R3");

        // hysteresis sweep up and down
        pair_hyst = {4'd7, 4'd4};
        for (int t = 30; t < 90; t++) begin zone_temp[1*TW +: TW] = 8'(t); step(2, "R2"); end
        for (int t = 90; t > 25; t--) begin zone_temp[1*TW +: TW] = 8'(t); step(2, "R2"); end

        // zone 0 correction clamp corners
        zone_bind = 8'b0000_0001;
        pair_base[7:0] = 8'd254; fill_offs(0, 15);
        zone_temp[7:0] = 8'd250; zone0_adj = 6'd31;
        step(4, "R4");
        pair_base[7:0] = 8'd0;
        zone_temp[7:0] = 8'd5; zone0_adj = 6'b100000;
        step(4, "R4");
        zone0_adj = 6'b111101; zone_temp[7:0] = 8'd20;
        step(4, "R4");

        // max-combining of all zones on both outputs
        zone_bind = '1;
        fill_offs(0, 3); pair_base = {8'd60, 8'd50};
        for (int i = 0; i < 200; i++) begin
            zone_temp = $urandom;
            step(1, "R5");
        end

        // ramps
        zone_bind = '0; zone_temp = '0; hot_bind = 4'b0001; ramp_div = 8'd3;
        hot_in = 2'b01;
        step(80, "R6");
        hot_in = 2'b00;
        step(80, "R7");
        hot_bind = 4'b0011;
        hot_in = 2'b10;
        step(30, "R7");
        hot_in = 2'b11;
        step(20, "R7");
        hot_in = 2'b01;
        step(90, "R7");
        hot_in = 2'b00;
        step(90, "R7");

        // manual, force, polarity
        for (int i = 0; i < 60; i++) begin
            man_en = 2'($urandom); man_duty = 8'($urandom);
            step(1, "R8");
        end
        man_duty = 8'h00; man_en = 2'b11;
        step(16, "R8");
        full_speed = 1;
        step(16, "R9");
        full_speed = 0;
        for (int i = 0; i < 80; i++) begin
            pwm_inv = 2'($urandom); man_duty = 8'($urandom); man_en = 2'b11;
            step(1, "R10");
        end
        man_en = 0; pwm_inv = 0;

        // halt while hot and warm
        zone_bind = '1; hot_bind = '1; hot_in = 2'b11; zone_temp = {4{8'd200}};
        step(40, "R11");
        run_en = 0;
        step(20, "R11");
        run_en = 1; hot_in = 0;
        step(60, "R11");

        // constrained random mix
        ramp_div = 8'd1;
        for (int i = 0; i < 4000; i++) begin
            for (int z = 0; z < NZONE; z++) begin
                int t;
                t = int'(zone_temp[z*TW +: TW]) + int'($urandom_range(0, 8)) - 4;
                if (t < 0) t = 0;
                if (t > 255) t = 255;
                zone_temp[z*TW +: TW] = 8'(t);
            end
            if ($urandom_range(0, 99) == 0) begin
                pair_offs = {$urandom, $urandom}; pair_base = 16'($urandom);
                pair_hyst = 8'($urandom); pair_floor = 8'($urandom);
                zone_bind = 8'($urandom); hot_bind = 4'($urandom);
                zone0_adj = 6'($urandom); pwm_inv = 2'($urandom);
            end
            if ($urandom_range(0, 19) == 0) hot_in = 2'($urandom);
            if ($urandom_range(0, 199) == 0) run_en = ~run_en;
            if ($urandom_range(0, 149) == 0) man_en = 2'($urandom);
            if ($urandom_range(0, 299) == 0) full_speed = ~full_speed;
            step(1, "R1/R2/R5/R6");
        end
        summary();
    end
endmodule